// File: doc/BRIEF.md
# Time-Shared Oscillator Bank

This block is a many-voice sine (or any waveform) synthesizer that needs only one adder for phase and one waveform lookup. One oscillator channel is served on each system clock. Each channel has its own phase word and its own frequency step, and both sit in on-chip RAM. When a channel is served, its stored phase moves on by its step, modulo 2^24. The twelve most significant phase bits select an entry of a shared 4096-entry waveform RAM. Every served channel's entry goes into a running sum. After every channel has been served once, the sum becomes one output sample.

With the default 512 channels and a 98.304 MHz clock, each channel is advanced at 192 kHz, and the output sample rate is also 192 kHz. A channel's tone frequency is `step * 192000 / 2^24`, so the step for a wanted frequency f is `f * 2^24 / 192000`. One step unit is about 0.0114 Hz.

A host loads the waveform entries and the per-channel steps through a single write port. The block keeps running while the host writes.

Top module: `poly_osc_bank`

## Requirements
- R1: While reset is high, and after it is released until the first complete sweep, `sampleValid` is 0 and `sampleOut` is 0. Reset sets every channel's phase and step to zero, so every channel reads waveform entry 0 until it is given a step.
- R2: Channels are served one per clock in ascending index order, 0 to 511, and then the order repeats. `sampleValid` is a single-clock pulse that comes exactly once every 512 clocks.
- R3: Each time a channel is served, its phase becomes `(phase + step) mod 2^24`. The waveform entry used on that visit is selected by bits 23:12 of the phase held before the advance.
- R4: `sampleOut` is the two's-complement sum of the 512 entries from one sweep, arithmetically shifted right by 9 (floor of the mean). It is updated only in the clock where `sampleValid` is 1 and holds between pulses.
- R5: The sum cannot overflow. If all 512 channels read +32767, the sample is +32767. If all read -32768, the sample is -32768.
- R6: A host write with `wrEn`=1 and `wrTable`=1 stores `wrData[15:0]` as a signed entry at waveform address `wrAddr[11:0]`. A write with `wrEn`=1 and `wrTable`=0 stores `wrData[23:0]` as the step of channel `wrAddr[8:0]`.
- R7: A step write to the channel that is read in the same clock does not change that visit; that visit still uses the old step. The new step applies from that channel's next visit. A step write to a channel that is served later in the sweep applies on that visit.
- R8: Reset leaves the waveform entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Host write strobe |
| wrTable | input | 1 | 1 = waveform entry write, 0 = channel step write |
| wrAddr | input | 12 | Waveform address, or channel index in bits 8:0 |
| wrData | input | 24 | Step value, or waveform entry in bits 15:0 |
| sampleOut | output | 16 | Signed output sample |
| sampleValid | output | 1 | One-clock strobe when a new sample is on `sampleOut` |

## Verification
Suppose one channel's phase or step is stored wrongly. The fault is summed into every later sample, so it shows at the ports within one or two sweeps, that is within about 1024 clocks of the bad write or bad advance. Its size is the waveform difference divided by 512. For this reason the bench uses large, irregular waveform entries so that a single-channel error shifts the sample by tens of codes. A fault in the channel counter or in the sweep boundary changes the 512-clock spacing of `sampleValid`, or it drops or doubles an entry, and this is seen at the very next pulse. The same-clock write case is checked by giving two channels the same step and comparing their one-sweep offset in the sums.

// File: rtl/poly_osc_pkg.sv
package poly_osc_pkg;

  // Per-stage strobes passed from the sequencer to the datapath.
  typedef struct packed {
    logic s1Vld;    // stage 1 holds a channel read from RAM
    logic s2Vld;    // stage 2 holds a table value to sum
    logic s2First;  // stage 2 value opens a sweep
    logic s2Last;   // stage 2 value closes a sweep
  } pipeStrobes_t;

endpackage

// File: rtl/poly_osc_ctrl.sv
module poly_osc_ctrl
  import poly_osc_pkg::*;
#(
  parameter int NumCh = 512,
  localparam int ChAw = $clog2(NumCh)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [ChAw-1:0] chIdx,
  output logic [ChAw-1:0] s1Ch,
  output pipeStrobes_t    stb
);

  localparam logic [ChAw-1:0] LastCh = ChAw'(NumCh - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      chIdx <= '0;
      s1Ch  <= '0;
      stb   <= '0;
    end else begin
      chIdx       <= (chIdx == LastCh) ? '0 : chIdx + 1'b1;
      s1Ch        <= chIdx;
      stb.s1Vld   <= 1'b1;
      stb.s2Vld   <= stb.s1Vld;
      stb.s2First <= stb.s1Vld && (s1Ch == '0);
      stb.s2Last  <= stb.s1Vld && (s1Ch == LastCh);
    end
  end

  // R2: a new sweep only opens right after the previous one closed
  a_r2_sweep_order: assert property (@(posedge clk) disable iff (rst)
    (stb.s2Vld && stb.s2First && $past(stb.s2Vld)) |-> $past(stb.s2Last));

  // R2: first and last never coincide in a multi-channel bank
  a_r2_first_last_apart: assert property (@(posedge clk) disable iff (rst)
    !(stb.s2First && stb.s2Last));

endmodule

// File: rtl/poly_osc_datapath.sv
module poly_osc_datapath
  import poly_osc_pkg::*;
#(
  parameter int NumCh  = 512,
  parameter int PhaseW = 24,
  parameter int TblAw  = 12,
  parameter int SampW  = 16,
  parameter int HostAw = 12,
  localparam int ChAw  = $clog2(NumCh),
  localparam int SumW  = SampW + ChAw,
  localparam int TblN  = 1 << TblAw
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ChAw-1:0]   chIdx,
  input  logic [ChAw-1:0]   s1Ch,
  input  pipeStrobes_t      stb,
  input  logic              wrEn,
  input  logic              wrTable,
  input  logic [HostAw-1:0] wrAddr,
  input  logic [PhaseW-1:0] wrData,
  output logic [SampW-1:0]  sampleOut,
  output logic              sampleValid
);

  logic [PhaseW-1:0] phRam  [NumCh];
  logic [PhaseW-1:0] incRam [NumCh];
  logic [SampW-1:0]  tblRam [TblN];
  logic              phSeen [NumCh];
  logic              incSeen[NumCh];

  logic [PhaseW-1:0] phRaw, incRaw, phCur, incCur, phNext;
  logic              phOk, incOk;
  logic signed [SampW-1:0] tblQ;
  logic signed [SumW-1:0]  acc, addend, accNext;
  logic              hostInc, hostTbl;
  logic [ChAw-1:0]   wrCh;

  assign hostInc = wrEn && !wrTable;
  assign hostTbl = wrEn && wrTable;
  assign wrCh    = wrAddr[ChAw-1:0];

  // Stage 0 -> 1: read a channel's phase and step.
  always_ff @(posedge clk) begin
    phRaw  <= phRam[chIdx];
    incRaw <= incRam[chIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phOk  <= 1'b0;
      incOk <= 1'b0;
    end else begin
      phOk  <= phSeen[chIdx];
      incOk <= incSeen[chIdx];
    end
  end

  // A word that has never been written since reset reads as zero.
  assign phCur  = phOk  ? phRaw  : '0;
  assign incCur = incOk ? incRaw : '0;
  assign phNext = phCur + incCur;

  always_ff @(posedge clk) begin
    if (stb.s1Vld) phRam[s1Ch] <= phNext;
  end

  always_ff @(posedge clk) begin
    if (hostInc) incRam[wrCh] <= wrData;
  end

  for (genvar g = 0; g < NumCh; g++) begin : g_seen
    always_ff @(posedge clk) begin
      if (rst) begin
        phSeen[g]  <= 1'b0;
        incSeen[g] <= 1'b0;
      end else begin
        if (stb.s1Vld && s1Ch == ChAw'(g)) phSeen[g]  <= 1'b1;
        if (hostInc && wrCh == ChAw'(g))  incSeen[g] <= 1'b1;
      end
    end
  end

  // Stage 1 -> 2: waveform lookup on the pre-advance phase.
  always_ff @(posedge clk) begin
    if (hostTbl) tblRam[wrAddr[TblAw-1:0]] <= wrData[SampW-1:0];
    tblQ <= tblRam[phCur[PhaseW-1 -: TblAw]];
  end

  // Stage 2: sweep sum.
  assign addend  = {{ChAw{tblQ[SampW-1]}}, tblQ};
  assign accNext = stb.s2First ? addend : acc + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc         <= '0;
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= stb.s2Vld && stb.s2Last;
      if (stb.s2Vld) acc <= accNext;
      if (stb.s2Vld && stb.s2Last) sampleOut <= accNext[SumW-1:ChAw];
    end
  end

  // R5: adding a value never flips the sum's sign against both operands
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (stb.s2Vld && !stb.s2First) |->
      !((acc[SumW-1] == addend[SumW-1]) && (accNext[SumW-1] != acc[SumW-1])));

  // R2: the strobe is one clock wide
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  // R4: closing a sweep raises the strobe on the next clock
  a_r4_sum_ready: assert property (@(posedge clk) disable iff (rst)
    (stb.s2Vld && stb.s2Last) |=> sampleValid);

  // R4: the sample holds between strobes
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |-> $stable(sampleOut));

  // R1: quiet right after reset release
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sampleValid && sampleOut == '0));

endmodule

// File: rtl/poly_osc_bank.sv
module poly_osc_bank
  import poly_osc_pkg::*;
#(
  parameter int NumCh  = 512,
  parameter int PhaseW = 24,
  parameter int TblAw  = 12,
  parameter int SampW  = 16,
  localparam int ChAw   = $clog2(NumCh),
  localparam int HostAw = (TblAw > ChAw) ? TblAw : ChAw
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrTable,
  input  logic [HostAw-1:0] wrAddr,
  input  logic [PhaseW-1:0] wrData,
  output logic [SampW-1:0]  sampleOut,
  output logic              sampleValid
);

  logic [ChAw-1:0] chIdx, s1Ch;
  pipeStrobes_t    stb;

  poly_osc_ctrl #(.NumCh(NumCh)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .chIdx (chIdx),
    .s1Ch  (s1Ch),
    .stb   (stb)
  );

  poly_osc_datapath #(
    .NumCh (NumCh),
    .PhaseW(PhaseW),
    .TblAw (TblAw),
    .SampW (SampW),
    .HostAw(HostAw)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .chIdx      (chIdx),
    .s1Ch       (s1Ch),
    .stb        (stb),
    .wrEn       (wrEn),
    .wrTable    (wrTable),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );

endmodule

// File: tb/sim_poly_osc_bank.sv
module sim_poly_osc_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic        wrTable = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [23:0] wrData = '0;
  logic [15:0] sampleOut;
  logic        sampleValid;

  int nChk = 0;
  int nBad = 0;

  int tblM [4096];
  int phM  [512];
  int incM [512];
  int pendCh = 0, pendInc = 0;
  bit pendVld = 1'b0;

  // channel / step vectors; all channels lie beyond the first write slots
  localparam int VecCh  [8] = '{64, 100, 200, 300, 400, 450, 510, 511};
  localparam int VecInc [8] = '{'h123456, 'hF00000, 'h000800, 'h7FFFFF,
                                'h400000, 'h00ABCD, 'hFFFFFF, 'h5A5A5A};

  always #10 clk = ~clk;

  poly_osc_bank u0 (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrTable(wrTable),
    .wrAddr(wrAddr), .wrData(wrData),
    .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outVal();
    return int'($signed(sampleOut));
  endfunction

  task automatic waitValid();
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sampleValid && n < 2000);
    if (!sampleValid) begin
      nChk++;
      nBad++;
      $display("FAIL R2: got no strobe in %0d clocks expected one per 512", n);
    end
  endtask

  task automatic hostWr(input bit tbl, input int addr, input int data);
    wrEn    = 1'b1;
    wrTable = tbl;
    wrAddr  = addr[11:0];
    wrData  = data[23:0];
    @(negedge clk);
    wrEn    = 1'b0;
  endtask

  function automatic int expSample();
    int s = 0;
    for (int c = 0; c < 512; c++) s += tblM[(phM[c] >> 12) & 4095];
    return s >>> 9;
  endfunction

  task automatic advance();
    for (int c = 0; c < 512; c++) phM[c] = (phM[c] + incM[c]) & 'hFFFFFF;
    if (pendVld) begin
      incM[pendCh] = pendInc;
      pendVld = 1'b0;
    end
  endtask

  task automatic clearModel();
    for (int c = 0; c < 512; c++) begin
      phM[c]  = 0;
      incM[c] = 0;
    end
    pendVld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: got no finish expected end within 200000 clocks");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int n;
    clearModel();
    repeat (4) @(negedge clk);
    check("R1 valid in reset", int'(sampleValid), 0);
    check("R1 sample in reset", outVal(), 0);
    rst = 1'b0;

    // R6: load the waveform; entry 0 full-scale positive
    hostWr(1'b1, 0, 32767);
    tblM[0] = 32767;
    for (int i = 1; i < 4096; i++) begin
      tblM[i] = int'(shortint'(i * 7919));
      hostWr(1'b1, i, tblM[i]);
    end
    waitValid();
    waitValid();
    check("R5 all +32767 (R1 zero steps)", outVal(), 32767);

    hostWr(1'b1, 0, -32768);
    tblM[0] = -32768;
    waitValid();
    waitValid();
    check("R5 all -32768", outVal(), -32768);

    // R2: one-clock strobe, 512-clock period
    @(negedge clk);
    check("R2 strobe one clock", int'(sampleValid), 0);
    n = 1;
    while (!sampleValid && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check("R2 strobe period", n, 512);
    @(negedge clk);
    check("R4 sample holds", outVal(), -32768);

    hostWr(1'b1, 0, 0);
    tblM[0] = 0;
    waitValid();
    waitValid();
    check("R4 zero sum", outVal(), expSample());
    advance();

    // R3/R6: walk the step vectors, then follow the sums
    for (int v = 0; v < 8; v++) begin
      hostWr(1'b0, VecCh[v], VecInc[v]);
      incM[VecCh[v]] = VecInc[v];
    end
    for (int s = 0; s < 12; s++) begin
      waitValid();
      check("R3 phase walk", outVal(), expSample());
      advance();
    end

    // R7: same-clock write to channel 2, normal write to channel 30
    hostWr(1'b0, 2, 'h300000);
    pendCh  = 2;
    pendInc = 'h300000;
    pendVld = 1'b1;
    hostWr(1'b0, 30, 'h300000);
    incM[30] = 'h300000;
    for (int s = 0; s < 6; s++) begin
      waitValid();
      check("R7 write collision", outVal(), expSample());
      advance();
    end

    // R8/R1: reset mid-run keeps the table, clears phases and steps
    hostWr(1'b1, 0, 1234);
    tblM[0] = 1234;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(sampleValid), 0);
    check("R1 sample in reset", outVal(), 0);
    rst = 1'b0;
    clearModel();
    @(negedge clk);
    check("R1 quiet after release", int'(sampleValid), 0);
    waitValid();
    check("R8 table kept", outVal(), 1234);
    waitValid();
    check("R1 steps cleared", outVal(), 1234);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule